// File: doc/BRIEF.md
# GNSS Carrier-Wipeoff Correlator Channel

This block is a single tracking channel for a digitized GNSS intermediate-frequency stream. Each clock carries one signed 8-bit sample. A 32-bit carrier phase accumulator addresses a computed sine/cosine table through its top 12 bits, and the sample is mixed to baseband in-phase and quadrature products. A 32-bit code phase accumulator steps through a loadable replica chip memory. Prompt, early and late copies of the replica are taken from that memory and multiply the mixed products.

Prompt sums are integrated over the carrier period, and early and late sums over the longer code period. The sums saturate and are handed over at each dump. A controlling processor writes new carrier and code frequency words, which take effect at the next dump of their own period. It reads the dumped sums and acknowledges them through a ready flag for each period. A shared sync pulse freezes the code and carrier phase state into measurement registers. The discriminators, loop filters, code generation and acquisition belong to the processor side.

Top module: `gnss_track_channel`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every sum output, both ready flags and every measurement output read zero. The carrier increment resets to 0x40000000, a quarter of the phase range, and the code increment resets to floor(2^32*1023/11200).
- R2: The carrier phase grows by the active carrier increment every clock, and each wrap past 2^32 adds one to the cycle count. With table address a (the phase bits 31:20), p = a mod 2048 and v = floor(127*p*(2048-p)/2^20), sine(a) is v when bit 11 of a is 0 and -v when it is 1. Cosine(a) is sine((a+1024) mod 4096). The in-phase product is sample*cosine and the quadrature product is sample*sine.
- R3: The code phase grows by the active code increment every clock. Each wrap moves the prompt chip index forward by one, from CODE_LEN-1 back to 0. A chip bit of 0 gives a +1 replica and a bit of 1 gives a -1 replica. A write strobe stores one bit at the given chip address on the next edge, and all bits reset to 0.
- R4: The early chip is the chip index reached after adding the half-spacing to the code phase. The late chip is the index reached after subtracting it, with the chip wrapping around the code length on carry or borrow. With the narrow select high the half-spacing is 2^28 (1/16 chip, a spacing of 1/8 chip), and with it low it is 2^30 (1/2 chip spacing).
- R5: The prompt sums add replica-multiplied products over CARR_PERIOD consecutive samples. The output shows the total, including the last sample, on the edge that ends the period. The prompt ready flag goes high on that same edge.
- R6: The early and late sums work the same way over CODE_PERIOD samples, with their own ready flag. Both periods count from the release of reset.
- R7: Every running sum clamps at the largest or smallest ACC_W-bit signed value instead of wrapping. No sign change is ever applied to a sum inside a period.
- R8: An acknowledge input clears its ready flag on the next edge. A dump on the same edge keeps the flag high.
- R9: A written frequency word is held pending. It becomes the active increment on the edge that ends the next period of its own kind (carrier words use the carrier period, code words the code period). A write on that same edge waits for the following dump.
- R10: A sync pulse copies the chip index, the code phase, the carrier phase and the cycle count, as held before that edge, into the measurement outputs. Without sync the measurement outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_in | input | 8 | Signed IF sample |
| carr_word_we | input | 1 | Carrier word write strobe |
| carr_word | input | 32 | Carrier increment word |
| code_word_we | input | 1 | Code word write strobe |
| code_word | input | 32 | Code increment word |
| el_narrow | input | 1 | 1: 1/8 chip spacing, 0: 1/2 chip spacing |
| chip_wr_en | input | 1 | Replica memory write strobe |
| chip_wr_addr | input | CHIP_AW | Replica memory address |
| chip_wr_bit | input | 1 | Replica bit to store |
| sync_pulse | input | 1 | Measurement latch strobe |
| prompt_ack | input | 1 | Clears prompt ready |
| el_ack | input | 1 | Clears early/late ready |
| prompt_ready | output | 1 | Prompt sums dumped, not yet acknowledged |
| el_ready | output | 1 | Early/late sums dumped, not yet acknowledged |
| prompt_i | output | ACC_W | Dumped prompt in-phase sum |
| prompt_q | output | ACC_W | Dumped prompt quadrature sum |
| early_i | output | ACC_W | Dumped early in-phase sum |
| early_q | output | ACC_W | Dumped early quadrature sum |
| late_i | output | ACC_W | Dumped late in-phase sum |
| late_q | output | ACC_W | Dumped late quadrature sum |
| meas_chip | output | CHIP_AW | Latched chip index |
| meas_code_phase | output | 32 | Latched code phase |
| meas_carr_phase | output | 32 | Latched carrier phase |
| meas_carr_cycles | output | 32 | Latched carrier cycle count |

## Verification
Each result is registered once. A sample presented before an edge reaches the dumped sums on that edge when the edge closes a period. A sync, acknowledge or word write shows its effect one edge later. A new increment first moves the phase on the edge after the dump that activates it. The reference model advances on the same edge as the design, the checks read the outputs on the falling edge that follows, and every output is compared on every cycle. Dedicated passes cover the saturation limit, both spacings, memory loading while the channel runs, acknowledges that coincide with dumps, and word writes.

// File: rtl/gnss_corr_pkg.sv
package gnss_corr_pkg;

    localparam logic [31:0] CARR_INC_RESET = 32'h4000_0000;
    localparam logic [31:0] CODE_INC_RESET = 32'((64'd4294967296 * 64'd1023) / 64'd11200);
    localparam logic [31:0] HALF_NARROW    = 32'h1000_0000;
    localparam logic [31:0] HALF_WIDE      = 32'h4000_0000;

    typedef struct packed {
        logic signed [15:0] i;
        logic signed [15:0] q;
    } iq_prod_t;

    typedef struct packed {
        logic prompt;
        logic early;
        logic late;
    } replica_bits_t;

    // Parabolic sine over a 4096-entry address space, amplitude 127.
    function automatic logic signed [7:0] wave_sine(input logic [11:0] addr);
        logic [10:0] p;
        logic [31:0] prod;
        logic [7:0]  mag;
        p    = addr[10:0];
        prod = 32'd127 * {21'd0, p} * (32'd2048 - {21'd0, p});
        mag  = prod[27:20];
        return addr[11] ? -$signed(mag) : $signed(mag);
    endfunction

    function automatic logic signed [15:0] apply_replica(input logic signed [15:0] v,
                                                         input logic chip_bit);
        return chip_bit ? -v : v;
    endfunction

endpackage

// File: rtl/gnss_dump_timer.sv
module gnss_dump_timer #(
    parameter int PERIOD = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(PERIOD)); // R5
endmodule

// File: rtl/gnss_carrier_nco.sv
module gnss_carrier_nco
    import gnss_corr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_we,
    input  logic [31:0]       word,
    input  logic              dump,
    output logic [31:0]       phase,
    output logic [31:0]       cycles,
    output logic signed [7:0] sine,
    output logic signed [7:0] cosine
);
    logic [31:0] inc_active, inc_pending;
    logic [32:0] phase_sum;

    assign phase_sum = {1'b0, phase} + {1'b0, inc_active};
    assign sine      = wave_sine(phase[31:20]);
    assign cosine    = wave_sine(phase[31:20] + 12'd1024);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= '0;
            cycles      <= '0;
            inc_active  <= CARR_INC_RESET;
            inc_pending <= CARR_INC_RESET;
        end else begin
            phase  <= phase_sum[31:0];
            cycles <= cycles + {31'd0, phase_sum[32]};
            if (dump)    inc_active  <= inc_pending;
            if (word_we) inc_pending <= word;
        end
    end

    AST_CARR_INC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dump |=> $stable(inc_active)); // R9
    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cycles == $past(cycles) || cycles == $past(cycles) + 32'd1)); // R2
endmodule

// File: rtl/gnss_code_nco.sv
module gnss_code_nco
    import gnss_corr_pkg::*;
#(
    parameter int CODE_LEN = 1023,
    parameter int CHIP_AW  = $clog2(CODE_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               word_we,
    input  logic [31:0]        word,
    input  logic               dump,
    input  logic               narrow,
    input  logic               mem_we,
    input  logic [CHIP_AW-1:0] mem_addr,
    input  logic               mem_bit,
    output logic [CHIP_AW-1:0] chip,
    output logic [31:0]        phase,
    output replica_bits_t      bits
);
    localparam logic [CHIP_AW-1:0] LAST = CHIP_AW'(CODE_LEN - 1);

    logic [CODE_LEN-1:0] chip_mem;
    logic [31:0]         inc_active, inc_pending, half;
    logic [32:0]         step_sum, early_sum, late_diff;
    logic [CHIP_AW-1:0]  chip_next, chip_prev, early_idx, late_idx;

    assign half      = narrow ? HALF_NARROW : HALF_WIDE;
    assign step_sum  = {1'b0, phase} + {1'b0, inc_active};
    assign early_sum = {1'b0, phase} + {1'b0, half};
    assign late_diff = {1'b0, phase} - {1'b0, half};
    assign chip_next = (chip == LAST) ? '0 : chip + 1'b1;
    assign chip_prev = (chip == '0) ? LAST : chip - 1'b1;
    assign early_idx = early_sum[32] ? chip_next : chip;
    assign late_idx  = late_diff[32] ? chip_prev : chip;

    assign bits.prompt = chip_mem[chip];
    assign bits.early  = chip_mem[early_idx];
    assign bits.late   = chip_mem[late_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= '0;
            chip        <= '0;
            chip_mem    <= '0;
            inc_active  <= CODE_INC_RESET;
            inc_pending <= CODE_INC_RESET;
        end else begin
            phase <= step_sum[31:0];
            if (step_sum[32]) chip <= chip_next;
            if (dump)    inc_active  <= inc_pending;
            if (word_we) inc_pending <= word;
            if (mem_we && mem_addr <= LAST) chip_mem[mem_addr] <= mem_bit;
        end
    end

    AST_CHIP_RANGE: assert property (@(posedge clk) disable iff (rst)
        chip <= LAST); // R3
    AST_CODE_INC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dump |=> $stable(inc_active)); // R9
endmodule

// File: rtl/gnss_corr_acc.sv
module gnss_corr_acc
    import gnss_corr_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  iq_prod_t                prod,
    input  logic                    dump,
    output logic signed [ACC_W-1:0] out_i,
    output logic signed [ACC_W-1:0] out_q
);
    localparam int EXT = ACC_W + 1 - 16;
    localparam logic signed [ACC_W-1:0] SMAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SMIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] acc_i, acc_q, nxt_i, nxt_q;

    function automatic logic signed [ACC_W-1:0] sat_add(input logic signed [ACC_W-1:0] a,
                                                        input logic signed [15:0] b);
        logic [ACC_W:0] s;
        s = {a[ACC_W-1], a} + {{EXT{b[15]}}, b};
        if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? SMIN : SMAX;
        return s[ACC_W-1:0];
    endfunction

    assign nxt_i = sat_add(acc_i, prod.i);
    assign nxt_q = sat_add(acc_q, prod.q);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_i <= '0; acc_q <= '0; out_i <= '0; out_q <= '0;
        end else if (dump) begin
            acc_i <= '0; acc_q <= '0; out_i <= nxt_i; out_q <= nxt_q;
        end else begin
            acc_i <= nxt_i; acc_q <= nxt_q;
        end
    end

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (rst)
        (!acc_i[ACC_W-1] && !prod.i[15] && !dump) |=> !acc_i[ACC_W-1]); // R7
    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
        (acc_q[ACC_W-1] && prod.q[15] && !dump) |=> acc_q[ACC_W-1]); // R7
endmodule

// File: rtl/gnss_track_channel.sv
module gnss_track_channel
    import gnss_corr_pkg::*;
#(
    parameter int CODE_LEN    = 1023,
    parameter int CARR_PERIOD = 2240000,
    parameter int CODE_PERIOD = 11200000,
    parameter int ACC_W       = 32,
    parameter int CHIP_AW     = $clog2(CODE_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              samp_in,
    input  logic                    carr_word_we,
    input  logic [31:0]             carr_word,
    input  logic                    code_word_we,
    input  logic [31:0]             code_word,
    input  logic                    el_narrow,
    input  logic                    chip_wr_en,
    input  logic [CHIP_AW-1:0]      chip_wr_addr,
    input  logic                    chip_wr_bit,
    input  logic                    sync_pulse,
    input  logic                    prompt_ack,
    input  logic                    el_ack,
    output logic                    prompt_ready,
    output logic                    el_ready,
    output logic signed [ACC_W-1:0] prompt_i,
    output logic signed [ACC_W-1:0] prompt_q,
    output logic signed [ACC_W-1:0] early_i,
    output logic signed [ACC_W-1:0] early_q,
    output logic signed [ACC_W-1:0] late_i,
    output logic signed [ACC_W-1:0] late_q,
    output logic [CHIP_AW-1:0]      meas_chip,
    output logic [31:0]             meas_code_phase,
    output logic [31:0]             meas_carr_phase,
    output logic [31:0]             meas_carr_cycles
);
    logic              carr_dump, code_dump;
    logic [31:0]       carr_phase, carr_cycles, code_phase;
    logic signed [7:0] sin_v, cos_v;
    logic [CHIP_AW-1:0] chip;
    replica_bits_t     rbits;
    logic signed [15:0] s_ext, c_ext, n_ext, mix_i, mix_q;
    iq_prod_t          p_prod, e_prod, l_prod;

    gnss_dump_timer #(.PERIOD(CARR_PERIOD)) u_carr_timer (.clk(clk), .rst(rst), .tick(carr_dump));
    gnss_dump_timer #(.PERIOD(CODE_PERIOD)) u_code_timer (.clk(clk), .rst(rst), .tick(code_dump));

    gnss_carrier_nco u_carr (
        .clk(clk), .rst(rst), .word_we(carr_word_we), .word(carr_word), .dump(carr_dump),
        .phase(carr_phase), .cycles(carr_cycles), .sine(sin_v), .cosine(cos_v));

    gnss_code_nco #(.CODE_LEN(CODE_LEN), .CHIP_AW(CHIP_AW)) u_code (
        .clk(clk), .rst(rst), .word_we(code_word_we), .word(code_word), .dump(code_dump),
        .narrow(el_narrow), .mem_we(chip_wr_en), .mem_addr(chip_wr_addr), .mem_bit(chip_wr_bit),
        .chip(chip), .phase(code_phase), .bits(rbits));

    // Carrier wipeoff, pilot only: no data-bit sign applied.
    assign s_ext = {{8{samp_in[7]}}, samp_in};
    assign c_ext = {{8{cos_v[7]}}, cos_v};
    assign n_ext = {{8{sin_v[7]}}, sin_v};
    assign mix_i = s_ext * c_ext;
    assign mix_q = s_ext * n_ext;

    assign p_prod = '{i: apply_replica(mix_i, rbits.prompt), q: apply_replica(mix_q, rbits.prompt)};
    assign e_prod = '{i: apply_replica(mix_i, rbits.early),  q: apply_replica(mix_q, rbits.early)};
    assign l_prod = '{i: apply_replica(mix_i, rbits.late),   q: apply_replica(mix_q, rbits.late)};

    gnss_corr_acc #(.ACC_W(ACC_W)) u_acc_prompt (.clk(clk), .rst(rst), .prod(p_prod),
        .dump(carr_dump), .out_i(prompt_i), .out_q(prompt_q));
    gnss_corr_acc #(.ACC_W(ACC_W)) u_acc_early (.clk(clk), .rst(rst), .prod(e_prod),
        .dump(code_dump), .out_i(early_i), .out_q(early_q));
    gnss_corr_acc #(.ACC_W(ACC_W)) u_acc_late (.clk(clk), .rst(rst), .prod(l_prod),
        .dump(code_dump), .out_i(late_i), .out_q(late_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            prompt_ready     <= 1'b0;
            el_ready         <= 1'b0;
            meas_chip        <= '0;
            meas_code_phase  <= '0;
            meas_carr_phase  <= '0;
            meas_carr_cycles <= '0;
        end else begin
            if (carr_dump)       prompt_ready <= 1'b1;
            else if (prompt_ack) prompt_ready <= 1'b0;
            if (code_dump)       el_ready <= 1'b1;
            else if (el_ack)     el_ready <= 1'b0;
            if (sync_pulse) begin
                meas_chip        <= chip;
                meas_code_phase  <= code_phase;
                meas_carr_phase  <= carr_phase;
                meas_carr_cycles <= carr_cycles;
            end
        end
    end

    AST_READY_ON_DUMP: assert property (@(posedge clk) disable iff (rst)
        carr_dump |=> prompt_ready); // R5
    AST_EL_READY_ON_DUMP: assert property (@(posedge clk) disable iff (rst)
        code_dump |=> el_ready); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (prompt_ack && !carr_dump) |=> !prompt_ready); // R8
    AST_MEAS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sync_pulse |=> ($stable(meas_code_phase) && $stable(meas_carr_phase)
                         && $stable(meas_carr_cycles) && $stable(meas_chip))); // R10
endmodule

// File: tb/gnss_track_channel_bench.sv
module gnss_track_channel_bench;
    localparam int LEN = 13;
    localparam int CP  = 40;
    localparam int KP  = 100;
    localparam int AW  = 18;
    localparam int CAW = $clog2(LEN);
    localparam longint SMAX = (64'sd1 <<< (AW - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (AW - 1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] samp_in = '0;
    logic carr_word_we = 1'b0, code_word_we = 1'b0, el_narrow = 1'b0;
    logic [31:0] carr_word = '0, code_word = '0;
    logic chip_wr_en = 1'b0, chip_wr_bit = 1'b0;
    logic [CAW-1:0] chip_wr_addr = '0;
    logic sync_pulse = 1'b0, prompt_ack = 1'b0, el_ack = 1'b0;
    logic prompt_ready, el_ready;
    logic signed [AW-1:0] prompt_i, prompt_q, early_i, early_q, late_i, late_q;
    logic [CAW-1:0] meas_chip;
    logic [31:0] meas_code_phase, meas_carr_phase, meas_carr_cycles;

    always #2 clk = ~clk;

    gnss_track_channel #(.CODE_LEN(LEN), .CARR_PERIOD(CP), .CODE_PERIOD(KP), .ACC_W(AW))
    u_gnss_track_channel (
        .clk(clk), .rst(rst), .samp_in(samp_in), .carr_word_we(carr_word_we), .carr_word(carr_word),
        .code_word_we(code_word_we), .code_word(code_word), .el_narrow(el_narrow),
        .chip_wr_en(chip_wr_en), .chip_wr_addr(chip_wr_addr), .chip_wr_bit(chip_wr_bit),
        .sync_pulse(sync_pulse), .prompt_ack(prompt_ack), .el_ack(el_ack),
        .prompt_ready(prompt_ready), .el_ready(el_ready), .prompt_i(prompt_i), .prompt_q(prompt_q),
        .early_i(early_i), .early_q(early_q), .late_i(late_i), .late_q(late_q),
        .meas_chip(meas_chip), .meas_code_phase(meas_code_phase),
        .meas_carr_phase(meas_carr_phase), .meas_carr_cycles(meas_carr_cycles));

    int compared = 0, mismatched = 0;
    string scen = "R1";
    bit seen_max = 0;

    // Reference model state
    longint m_cph, m_cinc, m_cpend, m_cyc, m_kph, m_kinc, m_kpend;
    int m_chip, m_ccnt, m_kcnt;
    bit m_mem[LEN];
    longint a_pi, a_pq, a_ei, a_eq, a_li, a_lq;
    longint o_pi, o_pq, o_ei, o_eq, o_li, o_lq;
    bit m_prdy, m_erdy;
    longint ms_chip, ms_kph, ms_cph, ms_cyc;
    localparam longint TWO32 = 64'd4294967296;

    function automatic int wave(int a);
        int p, v;
        p = a % 2048;
        v = (127 * p * (2048 - p)) >>> 20;
        return ((a % 4096) >= 2048) ? -v : v;
    endfunction

    function automatic longint clampadd(longint a, longint b);
        longint s = a + b;
        if (s > SMAX) return SMAX;
        if (s < SMIN) return SMIN;
        return s;
    endfunction

    function automatic int nxt(int c); return (c == LEN - 1) ? 0 : c + 1; endfunction
    function automatic int prv(int c); return (c == 0) ? LEN - 1 : c - 1; endfunction

    function automatic bit prompt_bit(); return m_mem[m_chip]; endfunction

    function automatic int cur_cos(); return wave(int'(m_cph >> 20) + 1024); endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cph = 0; m_cinc = 64'h4000_0000; m_cpend = 64'h4000_0000; m_cyc = 0;
            m_kph = 0; m_kinc = (TWO32 * 1023) / 11200; m_kpend = m_kinc; m_chip = 0;
            m_ccnt = 0; m_kcnt = 0;
            foreach (m_mem[k]) m_mem[k] = 0;
            a_pi = 0; a_pq = 0; a_ei = 0; a_eq = 0; a_li = 0; a_lq = 0;
            o_pi = 0; o_pq = 0; o_ei = 0; o_eq = 0; o_li = 0; o_lq = 0;
            m_prdy = 0; m_erdy = 0; ms_chip = 0; ms_kph = 0; ms_cph = 0; ms_cyc = 0;
        end else begin
            int addr, s, ci, si, ec, lc;
            longint half, pr, er, lr;
            bit cd, kd;
            addr = int'(m_cph >> 20);
            s  = int'($signed(samp_in));
            ci = s * wave(addr + 1024);
            si = s * wave(addr);
            half = el_narrow ? 64'h1000_0000 : 64'h4000_0000;
            ec = (m_kph + half >= TWO32) ? nxt(m_chip) : m_chip;
            lc = (m_kph - half < 0) ? prv(m_chip) : m_chip;
            pr = m_mem[m_chip] ? -1 : 1;
            er = m_mem[ec] ? -1 : 1;
            lr = m_mem[lc] ? -1 : 1;
            cd = (m_ccnt == CP - 1);
            kd = (m_kcnt == KP - 1);
            a_pi = clampadd(a_pi, pr * ci); a_pq = clampadd(a_pq, pr * si);
            a_ei = clampadd(a_ei, er * ci); a_eq = clampadd(a_eq, er * si);
            a_li = clampadd(a_li, lr * ci); a_lq = clampadd(a_lq, lr * si);
            if (cd) begin o_pi = a_pi; o_pq = a_pq; a_pi = 0; a_pq = 0; end
            if (kd) begin
                o_ei = a_ei; o_eq = a_eq; o_li = a_li; o_lq = a_lq;
                a_ei = 0; a_eq = 0; a_li = 0; a_lq = 0;
            end
            if (cd) m_prdy = 1; else if (prompt_ack) m_prdy = 0;
            if (kd) m_erdy = 1; else if (el_ack) m_erdy = 0;
            if (sync_pulse) begin ms_chip = m_chip; ms_kph = m_kph; ms_cph = m_cph; ms_cyc = m_cyc; end
            m_cph = m_cph + m_cinc;
            if (m_cph >= TWO32) begin m_cph -= TWO32; m_cyc = (m_cyc + 1) % TWO32; end
            m_kph = m_kph + m_kinc;
            if (m_kph >= TWO32) begin m_kph -= TWO32; m_chip = nxt(m_chip); end
            if (cd) m_cinc = m_cpend;
            if (carr_word_we) m_cpend = carr_word;
            if (kd) m_kinc = m_kpend;
            if (code_word_we) m_kpend = code_word;
            if (chip_wr_en && chip_wr_addr < LEN) m_mem[chip_wr_addr] = chip_wr_bit;
            m_ccnt = cd ? 0 : m_ccnt + 1;
            m_kcnt = kd ? 0 : m_kcnt + 1;
        end
    end

    task automatic check(string req, string name, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, scen, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R5", "prompt_i", longint'(prompt_i), o_pi);
            check("R2", "prompt_q", longint'(prompt_q), o_pq);
            check("R4", "early_i", longint'(early_i), o_ei);
            check("R4", "early_q", longint'(early_q), o_eq);
            check("R6", "late_i", longint'(late_i), o_li);
            check("R6", "late_q", longint'(late_q), o_lq);
            check("R8", "prompt_ready", longint'(prompt_ready), longint'(m_prdy));
            check("R8", "el_ready", longint'(el_ready), longint'(m_erdy));
            check("R3", "meas_chip", longint'(meas_chip), ms_chip);
            check("R9", "meas_code_phase", longint'(meas_code_phase), ms_kph);
            check("R10", "meas_carr_phase", longint'(meas_carr_phase), ms_cph);
            check("R2", "meas_carr_cycles", longint'(meas_carr_cycles), ms_cyc);
            if (longint'(prompt_i) == SMAX) seen_max = 1;
        end
    end

    task automatic run(int n, int sync_every, bit acks);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            samp_in    = 8'($urandom);
            sync_pulse = (sync_every > 0) && ((k % sync_every) == 3);
            prompt_ack = acks && ($urandom_range(0, 3) == 0);
            el_ack     = acks && ($urandom_range(0, 3) == 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is still high
        check("R1", "reset prompt_i", longint'(prompt_i), 0);
        check("R1", "reset ready", longint'({prompt_ready, el_ready}), 0);
        check("R1", "reset meas", longint'(meas_carr_phase) + longint'(meas_carr_cycles), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "released prompt_ready", longint'(prompt_ready), 0);
        check("R1", "released early_i", longint'(early_i), 0);

        scen = "R2"; run(150, 0, 0);

        scen = "R3";
        for (int a = 0; a < LEN; a++) begin
            @(negedge clk);
            samp_in = 8'($urandom);
            chip_wr_en = 1'b1; chip_wr_addr = CAW'(a); chip_wr_bit = 1'($urandom);
        end
        @(negedge clk); chip_wr_en = 1'b0;
        code_word_we = 1'b1; code_word = 32'h6000_0000;
        @(negedge clk); code_word_we = 1'b0;
        run(250, 17, 0);

        scen = "R4"; el_narrow = 1'b1; run(250, 0, 1); el_narrow = 1'b0;

        scen = "R10"; run(120, 7, 0);

        scen = "R8"; run(200, 0, 1);

        scen = "R9";
        @(negedge clk); carr_word_we = 1'b1; carr_word = 32'h1234_5678;
        code_word_we = 1'b1; code_word = 32'h2345_6789;
        @(negedge clk); carr_word_we = 1'b0; code_word_we = 1'b0;
        run(250, 11, 1);

        scen = "R7";
        @(negedge clk); carr_word_we = 1'b1; carr_word = 32'h4000_0000;
        @(negedge clk); carr_word_we = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            samp_in = ((cur_cos() >= 0) == !prompt_bit()) ? 8'sd127 : -8'sd128;
        end
        // R7: prompt sum must have been held at the positive limit
        check("R7", "saturated prompt_i seen", longint'(seen_max), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog [%s]: actual timeout expected completion", scen);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule